// File: doc/BRIEF.md
# Microcoded Multicycle Control Sequencer

This block steers a multicycle processor datapath from a small internal microinstruction store rather than from hand-built next-state logic. A 4-bit micro-address register selects one 18-bit microword per clock cycle. Sixteen bits of that word drive the datapath control pins directly. The remaining 2-bit sequencing field picks the next micro-address. The choices are a restart at the fetch word, a lookup in one of two opcode-indexed dispatch tables, or a step to the following word.

The microcode covers five instruction classes: register-register ALU operations, loads, stores, branch-if-equal and jump. Every class first passes through the shared fetch word (address 0) and the decode word (address 1). It then runs its own completion words and returns to fetch. The 6-bit opcode is consulted only while a dispatching word is current. At all other times it is ignored. All pins are plain level signals with no handshake. The datapath samples the control pins on each rising edge, the same edge on which the sequencer advances.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low, `upc` is 0. On release, the sequencer runs the fetch word first.
- R2: At micro-address 0 the controls are as follows. `mem_read`, `ir_write` and `pc_write` are 1. `alu_src_b` is 01. `alu_op`, `alu_src_a`, `i_or_d` and `pc_source` are 0. All other controls are 0.
- R3: A word whose sequencing field is "step" (code 11) leads to `upc`+1 on the next edge. This applies to word 0 (goes to 1), word 3 (goes to 4) and word 6 (goes to 7).
- R4: A word whose sequencing field is "restart" (code 00) leads to `upc` = 0 on the next edge. This applies to words 4, 5, 7, 8 and 9.
- R5: Word 1 uses the first dispatch table (code 01), which maps the opcode to a micro-address. Opcode 0x00 (register ALU) goes to 6. Opcodes 0x23 (load) and 0x2B (store) go to 2. Opcode 0x04 (branch) goes to 8. Opcode 0x02 (jump) goes to 9.
- R6: Word 2 uses the second dispatch table (code 10). It sends opcode 0x23 to 3 and opcode 0x2B to 5.
- R7: The first dispatch table returns 0 for any opcode not listed in R5.
- R8: The second dispatch table returns 0 for any opcode other than 0x23 and 0x2B. This holds even if the opcode changed after word 1.
- R9: The opcode has no effect on the next address while the current word does not dispatch (words 0 and 3 to 9).
- R10: Controls per word, with `alu_src_b` and `alu_op` in binary and every control not named at 0:
  - 1: `alu_src_b`=11.
  - 2: `alu_src_a`=1, `alu_src_b`=10.
  - 3: `mem_read`=1, `i_or_d`=1.
  - 4: `reg_write`=1, `mem_to_reg`=1.
  - 5: `mem_write`=1, `i_or_d`=1.
  - 6: `alu_src_a`=1, `alu_op`=10.
  - 7: `reg_write`=1, `reg_dst`=1.
  - 8: `alu_src_a`=1, `alu_op`=01, `pc_write_cond`=1, `pc_source`=01.
  - 9: `pc_write`=1, `pc_source`=10.
- R11: Instruction lengths from fetch to the next fetch are 5 cycles for a load, 4 for a store, 4 for a register ALU operation, 3 for a branch and 3 for a jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode of the instruction register |
| alu_op | output | 2 | ALU mode: 00 add, 01 subtract, 10 function field |
| alu_src_a | output | 1 | First ALU operand: 0 PC, 1 register A |
| alu_src_b | output | 2 | Second ALU operand: 00 B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| reg_write | output | 1 | Register file write enable |
| mem_to_reg | output | 1 | Write data taken from the memory data register |
| reg_dst | output | 1 | Destination register from the rd field |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| i_or_d | output | 1 | Memory address from ALU result register rather than PC |
| ir_write | output | 1 | Instruction register load |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write gated by ALU zero |
| pc_source | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| upc | output | 4 | Current micro-address |

## Verification
Two functions can act in the same cycle. The second dispatch lookup at word 2 can coincide with an opcode that is no longer the one the first lookup used, because the opcode is only read, never held. The bench provokes this by presenting a load opcode at word 1 and a branch opcode at word 2. The scoreboard then expects a restart at 0 one cycle later instead of the load's memory word. The bench also changes the opcode during every non-dispatching word. The scoreboard judges these cycles by comparing each cycle's micro-address and control bundle against a path computed from the requirements alone.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  localparam int UPC_W = 4;
  localparam int OPC_W = 6;
  localparam int NUM_WORDS = 1 << UPC_W;
  localparam int NUM_OPC = 1 << OPC_W;

  localparam logic [OPC_W-1:0] OPC_RALU  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BRZ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'h02;

  typedef enum logic [1:0] {
    SEQ_RESTART = 2'b00,
    SEQ_TBL_A   = 2'b01,
    SEQ_TBL_B   = 2'b10,
    SEQ_STEP    = 2'b11
  } seq_e;

  // 18-bit microword, most significant field first.
  typedef struct packed {
    logic [1:0] alu_op;
    logic       src_a;
    logic [1:0] src_b;
    logic       reg_write;
    logic       mem_to_reg;
    logic       reg_dst;
    logic       mem_read;
    logic       mem_write;
    logic       i_or_d;
    logic       ir_write;
    logic       pc_write;
    logic       pc_write_cond;
    logic [1:0] pc_source;
    seq_e       seq;
  } uword_t;
endpackage

// File: rtl/ucs_store.sv
module ucs_store
  import ucs_pkg::*;
(
  input  logic [UPC_W-1:0] addr,
  output uword_t           word
);
  function automatic uword_t build_word(input int a);
    uword_t w;
    w = '0;
    w.seq = SEQ_RESTART;
    case (a)
      0: begin
        w.mem_read = 1'b1; w.ir_write = 1'b1; w.pc_write = 1'b1;
        w.src_b = 2'b01; w.seq = SEQ_STEP;
      end
      1: begin w.src_b = 2'b11; w.seq = SEQ_TBL_A; end
      2: begin w.src_a = 1'b1; w.src_b = 2'b10; w.seq = SEQ_TBL_B; end
      3: begin w.mem_read = 1'b1; w.i_or_d = 1'b1; w.seq = SEQ_STEP; end
      4: begin w.reg_write = 1'b1; w.mem_to_reg = 1'b1; end
      5: begin w.mem_write = 1'b1; w.i_or_d = 1'b1; end
      6: begin w.src_a = 1'b1; w.alu_op = 2'b10; w.seq = SEQ_STEP; end
      7: begin w.reg_write = 1'b1; w.reg_dst = 1'b1; end
      8: begin
        w.src_a = 1'b1; w.alu_op = 2'b01;
        w.pc_write_cond = 1'b1; w.pc_source = 2'b01;
      end
      9: begin w.pc_write = 1'b1; w.pc_source = 2'b10; end
      default: w = w;
    endcase
    return w;
  endfunction

  uword_t rom [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    assign rom[g] = build_word(g);
  end

  assign word = rom[addr];
endmodule

// File: rtl/ucs_dispatch.sv
module ucs_dispatch
  import ucs_pkg::*;
#(
  parameter int TABLE_ID = 1
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [UPC_W-1:0] target
);
  function automatic logic [UPC_W-1:0] first_tbl(input logic [OPC_W-1:0] op);
    case (op)
      OPC_RALU:            return UPC_W'(6);
      OPC_LOAD, OPC_STORE: return UPC_W'(2);
      OPC_BRZ:             return UPC_W'(8);
      OPC_JMP:             return UPC_W'(9);
      default:             return '0;
    endcase
  endfunction

  function automatic logic [UPC_W-1:0] second_tbl(input logic [OPC_W-1:0] op);
    case (op)
      OPC_LOAD:  return UPC_W'(3);
      OPC_STORE: return UPC_W'(5);
      default:   return '0;
    endcase
  endfunction

  logic [UPC_W-1:0] tbl [NUM_OPC];

  for (genvar g = 0; g < NUM_OPC; g++) begin : g_entry
    if (TABLE_ID == 1) begin : g_first
      assign tbl[g] = first_tbl(OPC_W'(g));
    end else begin : g_second
      assign tbl[g] = second_tbl(OPC_W'(g));
    end
  end

  assign target = tbl[opcode];
endmodule

// File: rtl/ucs_next.sv
module ucs_next
  import ucs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  seq_e             seq,
  input  logic [UPC_W-1:0] tgt_a,
  input  logic [UPC_W-1:0] tgt_b,
  output logic [UPC_W-1:0] upc_q
);
  logic [UPC_W-1:0] upc_d;

  always_comb begin
    unique case (seq)
      SEQ_RESTART: upc_d = '0;
      SEQ_TBL_A:   upc_d = tgt_a;
      SEQ_TBL_B:   upc_d = tgt_b;
      default:     upc_d = upc_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc_q <= '0;
    else        upc_q <= upc_d;
  end

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SEQ_STEP) |=> (upc_q == UPC_W'($past(upc_q) + 1'b1)));

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SEQ_RESTART) |=> (upc_q == '0));

  assert_tbl_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SEQ_TBL_A) |=> (upc_q inside {4'd0, 4'd2, 4'd6, 4'd8, 4'd9}));

  assert_tbl_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SEQ_TBL_B) |=> (upc_q inside {4'd0, 4'd3, 4'd5}));
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       opcode,
  output logic [1:0]       alu_op,
  output logic             alu_src_a,
  output logic [1:0]       alu_src_b,
  output logic             reg_write,
  output logic             mem_to_reg,
  output logic             reg_dst,
  output logic             mem_read,
  output logic             mem_write,
  output logic             i_or_d,
  output logic             ir_write,
  output logic             pc_write,
  output logic             pc_write_cond,
  output logic [1:0]       pc_source,
  output logic [3:0]       upc
);
  logic [UPC_W-1:0] upc_q;
  logic [UPC_W-1:0] tgt_a, tgt_b;
  uword_t           word;

  ucs_store u_store (.addr(upc_q), .word(word));

  ucs_dispatch #(.TABLE_ID(1)) u_tbl_a (.opcode(opcode), .target(tgt_a));
  ucs_dispatch #(.TABLE_ID(2)) u_tbl_b (.opcode(opcode), .target(tgt_b));

  ucs_next u_next (
    .clk(clk), .rst_n(rst_n), .seq(word.seq),
    .tgt_a(tgt_a), .tgt_b(tgt_b), .upc_q(upc_q)
  );

  assign alu_op        = word.alu_op;
  assign alu_src_a     = word.src_a;
  assign alu_src_b     = word.src_b;
  assign reg_write     = word.reg_write;
  assign mem_to_reg    = word.mem_to_reg;
  assign reg_dst       = word.reg_dst;
  assign mem_read      = word.mem_read;
  assign mem_write     = word.mem_write;
  assign i_or_d        = word.i_or_d;
  assign ir_write      = word.ir_write;
  assign pc_write      = word.pc_write;
  assign pc_write_cond = word.pc_write_cond;
  assign pc_source     = word.pc_source;
  assign upc           = upc_q;

  assert_fetch_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == '0) |-> (mem_read && ir_write && pc_write && alu_src_b == 2'b01));

  assert_mem_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_read, mem_write}));

  assert_pc_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_write, pc_write_cond}));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (upc == '0));
endmodule

// File: tb/ucode_sequencer_tb_top.sv
module ucode_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'h3F;
  logic [1:0] alu_op, alu_src_b, pc_source;
  logic alu_src_a, reg_write, mem_to_reg, reg_dst, mem_read, mem_write;
  logic i_or_d, ir_write, pc_write, pc_write_cond;
  logic [3:0] upc;

  int checks = 0;
  int failures = 0;

  logic [19:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  ucode_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .alu_op(alu_op), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
    .reg_write(reg_write), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst),
    .mem_read(mem_read), .mem_write(mem_write), .i_or_d(i_or_d),
    .ir_write(ir_write), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
    .pc_source(pc_source), .upc(upc)
  );

  wire [15:0] ctrl = {alu_op, alu_src_a, alu_src_b, reg_write, mem_to_reg,
                      reg_dst, mem_read, mem_write, i_or_d, ir_write,
                      pc_write, pc_write_cond, pc_source};

  // Expected controls per word, from R2 and R10.
  function automatic logic [15:0] exp_ctrl(input int s);
    case (s)
      0: return 16'b00_0_01_000_1001_10_00;
      1: return 16'b00_0_11_000_0000_00_00;
      2: return 16'b00_1_10_000_0000_00_00;
      3: return 16'b00_0_00_000_1010_00_00;
      4: return 16'b00_0_00_110_0000_00_00;
      5: return 16'b00_0_00_000_0110_00_00;
      6: return 16'b10_1_00_000_0000_00_00;
      7: return 16'b00_0_00_101_0000_00_00;
      8: return 16'b01_1_00_000_0000_01_01;
      9: return 16'b00_0_00_000_0000_10_10;
      default: return 16'h0;
    endcase
  endfunction

  // Next micro-address model from R3..R8.
  function automatic int exp_next(input int s, input logic [5:0] op);
    case (s)
      0: return 1;
      1: case (op)
           6'h00: return 6;
           6'h23, 6'h2B: return 2;
           6'h04: return 8;
           6'h02: return 9;
           default: return 0;
         endcase
      2: case (op)
           6'h23: return 3;
           6'h2B: return 5;
           default: return 0;
         endcase
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  // Driver: walks one instruction from fetch back to fetch.
  task automatic run_instr(input logic [5:0] op1, input logic [5:0] op2,
                           input logic [5:0] noise, input string tag,
                           input int exp_len);
    int s = 0;
    int n = 0;
    do begin
      logic [5:0] drv;
      drv = (s == 1) ? op1 : (s == 2) ? op2 : noise;
      opcode = drv;
      exp_q.push_back({4'(s), exp_ctrl(s)});
      tag_q.push_back(tag);
      @(posedge clk); #1;
      s = exp_next(s, drv);
      n++;
    end while (s != 0);
    checks++;
    if (n != exp_len) begin
      failures++;
      $display("FAIL R11 %s length actual=%0d expected=%0d", tag, n, exp_len);
    end
  endtask

  // Monitor: compares each cycle away from the active edge.
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [19:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({upc, ctrl} !== e) begin
        failures++;
        $display("FAIL %s upc/ctrl actual=%0d/%b expected=%0d/%b",
                 t, upc, ctrl, e[19:16], e[15:0]);
      end
    end
  end

  task automatic check_reset(input string tag);
    checks++;
    if (upc !== 4'd0 || ctrl !== exp_ctrl(0)) begin
      failures++;
      $display("FAIL %s reset actual=%0d/%b expected=0/%b",
               tag, upc, ctrl, exp_ctrl(0));
    end
  endtask

  task automatic run_all();
    repeat (3) @(posedge clk);
    #1;
    check_reset("R1 R2 in reset");
    rst_n = 1'b1;
    run_instr(6'h00, 6'h00, 6'h00, "R10 R3 R5 ralu", 4);
    run_instr(6'h23, 6'h23, 6'h23, "R6 R3 load", 5);
    run_instr(6'h2B, 6'h2B, 6'h2B, "R6 R4 store", 4);
    run_instr(6'h04, 6'h04, 6'h04, "R5 R4 branch", 3);
    run_instr(6'h02, 6'h02, 6'h02, "R5 R4 jump", 3);
    run_instr(6'h3F, 6'h3F, 6'h3F, "R7 undefined", 2);
    run_instr(6'h01, 6'h01, 6'h01, "R7 undefined2", 2);
    run_instr(6'h23, 6'h04, 6'h00, "R8 second table miss", 3);
    run_instr(6'h2B, 6'h00, 6'h23, "R8 second table miss2", 3);
    run_instr(6'h00, 6'h00, 6'h23, "R9 noise ralu", 4);
    run_instr(6'h23, 6'h23, 6'h02, "R9 noise load", 5);
    run_instr(6'h02, 6'h02, 6'h04, "R9 noise jump", 3);
    for (int k = 0; k < 64; k++) begin
      logic [5:0] op = 6'(k);
      run_instr(op, op, ~op, "R7 R5 sweep", (op == 6'h23) ? 5 :
                (op == 6'h2B || op == 6'h00) ? 4 :
                (op == 6'h04 || op == 6'h02) ? 3 : 2);
    end
    // Reset in the middle of a load: R1.
    opcode = 6'h23;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check_reset("R1 mid-run reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    run_instr(6'h04, 6'h04, 6'h00, "R1 after reset", 3);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard residue actual=%0d expected=0", exp_q.size());
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule